// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block receives a stereo serial audio stream made of a bit clock, a word clock and a serial data line. It runs entirely on the bit clock and samples both the word clock and the data on its rising edge. A static format input picks between two framings:

- I2S framing with 24-bit words.
- Right-justified framing with 20-bit words.

In both framings the most significant bit arrives first.

The receiver measures the length of every word-clock half and captures one word per half. It sign-extends each word to a common 24-bit width and pairs a left sample with the following right sample. When a complete pair has been captured it raises a one-cycle strobe together with the two samples. When both halves of the word clock last exactly 16 bit clocks, the block treats the words as 16-bit in either framing. A half that is shorter than the word length in force raises an error pulse instead, and no pair is delivered for that frame.

The block sits between the serial audio pins and a sample-rate filter path, and it is used as the front end of a converter. Crossing into the filter clock domain is left to the logic downstream.

Top module: `dual_fmt_audio_rx`

## Requirements
- R1: `fmt_i2s`=1 selects I2S framing with 24-bit words. `fmt_i2s`=0 selects right-justified framing with 20-bit words. Data and word clock are both sampled on the rising `bclk` edge, with the MSB first.
- R2: In I2S framing, the MSB of a word is the bit sampled on the second rising edge after the word clock changes. `wclk`=0 carries the left channel and `wclk`=1 the right channel.
- R3: In I2S framing, a half of more than 24 bit clocks is accepted. Only the first 24 bits, counted from the MSB, form the word, and any later bits in that half have no effect on the output.
- R4: In right-justified framing, the LSB is the bit sampled on the last rising edge before the word clock changes, and all earlier padding bits are discarded. `wclk`=1 carries the left channel and `wclk`=0 the right channel.
- R5: A word is treated as 16 bits, in either framing, when the half that carried it and the half before it each lasted exactly 16 bit clocks. When this happens, `len16_o` is 1 alongside the strobe.
- R6: A word shorter than 24 bits is sign-extended: every output bit above the word width copies the word's MSB.
- R7: `pair_stb_o` is high for exactly one cycle per valid frame. It rises on the edge that captures the right word, and `left_o`/`right_o` change only together with it.
- R8: A half shorter than the word length in force pulses `err_o` for one cycle and suppresses `pair_stb_o` for that frame.
- R9: The high and low halves of the word clock may have any length ratio, provided each half lasts at least one word length.
- R10: After reset the outputs are zero with no strobe. The first word-clock change after reset only arms the receiver and captures no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i2s | input | 1 | Static framing select: 1 = I2S/24-bit, 0 = right-justified/20-bit |
| wclk | input | 1 | Word (left/right) clock |
| sdata | input | 1 | Serial audio data, MSB first |
| left_o | output | 24 | Sign-extended left sample of the last valid pair |
| right_o | output | 24 | Sign-extended right sample of the last valid pair |
| pair_stb_o | output | 1 | One-cycle strobe: a new stereo pair is on the outputs |
| len16_o | output | 1 | The last delivered pair used 16-bit words |
| err_o | output | 1 | One-cycle pulse: a captured half was too short |

## Verification
The assertions check, on every cycle, the properties that hold cycle by cycle:

- The strobe lasts one cycle and follows a right-channel capture.
- An error pulse never coincides with a strobe.
- The I2S bit counter saturates and then freezes the shift register.
- A 16-bit pair comes from two 16-clock halves.
- Right-justified samples carry correct sign extension.
- The receiver stays silent until it is armed.

Only the bench's scenarios can show that the captured values are the right bits. This covers the MSB delay in I2S, the discarded padding in right-justified framing, the channel polarity of each framing, and the ignored bits past the 24th. The scenarios also cover automatic 16-bit detection, unequal half lengths and short halves, each against values the bench predicts on its own.

// File: rtl/srx_pkg.sv
package srx_pkg;

  // Width of every delivered sample.
  localparam int unsigned SMP_W = 24;

  // Word length in force for one captured half.
  function automatic int unsigned pick_len(
    input logic        is_i2s,
    input logic        is_short,
    input int unsigned i2s_w,
    input int unsigned rj_w,
    input int unsigned short_w
  );
    if (is_short)    return short_w;
    else if (is_i2s) return i2s_w;
    else             return rj_w;
  endfunction

  // Keep the low nbits of raw and copy its top bit into every higher bit.
  function automatic logic [SMP_W-1:0] sign_fill(
    input logic [SMP_W-1:0] raw,
    input int unsigned      nbits
  );
    logic [SMP_W-1:0] res;
    for (int unsigned i = 0; i < SMP_W; i++) begin
      res[i] = (i < nbits) ? raw[i] : raw[nbits-1];
    end
    return res;
  endfunction

endpackage

// File: rtl/srx_edge.sv
// Word-clock edge tracker: finds word-clock changes and measures half lengths.
module srx_edge #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wclk,
  output logic             flip,      // word clock changed on this edge
  output logic             latch,     // a complete half ends on this edge
  output logic             armed,     // a first change has been seen
  output logic             old_lvl,   // level of the half that just ended
  output logic [CNT_W-1:0] half_len,  // length of the half that just ended
  output logic [CNT_W-1:0] prev_len   // length of the half before it
);

  logic             ws_q;
  logic             armed_q;
  logic [CNT_W-1:0] pos_q;
  logic [CNT_W-1:0] prev_q;

  assign flip     = wclk ^ ws_q;
  assign latch    = flip & armed_q;
  assign armed    = armed_q;
  assign old_lvl  = ws_q;
  assign half_len = pos_q;
  assign prev_len = prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_q    <= 1'b0;
      armed_q <= 1'b0;
      pos_q   <= '0;
      prev_q  <= '0;
    end else begin
      ws_q <= wclk;
      if (flip) begin
        armed_q <= 1'b1;
        pos_q   <= CNT_W'(1);
        prev_q  <= armed_q ? pos_q : '0;
      end else if (pos_q != '1) begin
        pos_q <= pos_q + CNT_W'(1);
      end
    end
  end

  // R9: a new half always restarts its count at one edge
  a_r9_half_restart: assert property (@(posedge clk) disable iff (!rst_n)
    flip |=> (half_len == CNT_W'(1)));

endmodule

// File: rtl/srx_shift.sv
// Serial shifter. In right-justified framing it shifts on every edge. In
// I2S framing it stops after I2S_W bits of a word.
module srx_shift #(
  parameter int unsigned SMP_W = 24,
  parameter int unsigned I2S_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_i2s,
  input  logic             sdata,
  input  logic             flip,
  output logic [SMP_W-1:0] cand      // word as it stands at this edge
);

  localparam int unsigned BC_W = $clog2(I2S_W + 1);

  logic [SMP_W-1:0] sr_q;
  logic [BC_W-1:0]  bcnt_q;
  logic             take;
  logic [SMP_W-1:0] shifted;

  assign take    = !fmt_i2s || (bcnt_q < BC_W'(I2S_W));
  assign shifted = {sr_q[SMP_W-2:0], sdata};
  // In I2S the bit on the changing edge still belongs to the old word.
  // In right-justified framing it already belongs to the next word.
  assign cand    = (fmt_i2s && take) ? shifted : sr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q   <= '0;
      bcnt_q <= '0;
    end else begin
      if (take) sr_q <= shifted;
      if (flip)                            bcnt_q <= '0;
      else if (bcnt_q < BC_W'(I2S_W))      bcnt_q <= bcnt_q + BC_W'(1);
    end
  end

  // R3: the I2S bit counter never passes the word length
  a_r3_cnt_cap: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= BC_W'(I2S_W));

  // R3: once a full I2S word is held, extra bits leave it untouched
  a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_i2s && bcnt_q == BC_W'(I2S_W) && !flip) |=> (sr_q == $past(sr_q)));

endmodule

// File: rtl/srx_frame.sv
// Frame assembly: picks the word length, checks it, extends the sign and
// pairs the channels.
module srx_frame
  import srx_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned I2S_W   = 24,
  parameter int unsigned RJ_W    = 20,
  parameter int unsigned SHORT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fmt_i2s,
  input  logic             latch,
  input  logic             old_lvl,
  input  logic [CNT_W-1:0] half_len,
  input  logic [CNT_W-1:0] prev_len,
  input  logic [SMP_W-1:0] cand,
  output logic [SMP_W-1:0] left_o,
  output logic [SMP_W-1:0] right_o,
  output logic             pair_stb_o,
  output logic             len16_o,
  output logic             err_o
);

  logic             is_short;
  logic             is_left;
  logic             len_ok;
  int unsigned      wl;
  logic [SMP_W-1:0] smp;

  logic [SMP_W-1:0] left_hold_q;
  logic             left_ok_q;

  assign is_short = (half_len == CNT_W'(SHORT_W)) && (prev_len == CNT_W'(SHORT_W));
  assign wl       = pick_len(fmt_i2s, is_short, I2S_W, RJ_W, SHORT_W);
  assign len_ok   = (32'(half_len) >= wl);
  assign is_left  = fmt_i2s ? !old_lvl : old_lvl;
  assign smp      = sign_fill(cand, wl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_o      <= '0;
      right_o     <= '0;
      pair_stb_o  <= 1'b0;
      len16_o     <= 1'b0;
      err_o       <= 1'b0;
      left_hold_q <= '0;
      left_ok_q   <= 1'b0;
    end else begin
      pair_stb_o <= 1'b0;
      err_o      <= latch && !len_ok;
      if (latch) begin
        if (is_left) begin
          left_hold_q <= smp;
          left_ok_q   <= len_ok;
        end else begin
          left_ok_q <= 1'b0;
          if (len_ok && left_ok_q) begin
            left_o     <= left_hold_q;
            right_o    <= smp;
            len16_o    <= is_short;
            pair_stb_o <= 1'b1;
          end
        end
      end
    end
  end

  // R7: the strobe is a single-cycle pulse
  a_r7_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb_o |=> !pair_stb_o);

  // R7: the strobe follows the capture of a right-channel word
  a_r7_after_right: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb_o |-> ($past(latch) && ($past(old_lvl) == $past(fmt_i2s))));

  // R8: a short half and a delivered pair never coincide
  a_r8_err_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !pair_stb_o);

  // R5: a 16-bit pair comes from two halves of exactly 16 edges
  a_r5_len16_src: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_stb_o && len16_o) |->
      ($past(half_len) == CNT_W'(SHORT_W) && $past(prev_len) == CNT_W'(SHORT_W)));

  // R6: right-justified 20-bit samples carry a filled sign
  a_r6_rj_sext: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_stb_o && !len16_o && !fmt_i2s) |->
      ((right_o[SMP_W-1:RJ_W-1] == '0) || (right_o[SMP_W-1:RJ_W-1] == '1)));

endmodule

// File: rtl/dual_fmt_audio_rx.sv
module dual_fmt_audio_rx
  import srx_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned I2S_W   = 24,
  parameter int unsigned RJ_W    = 20,
  parameter int unsigned SHORT_W = 16
) (
  input  logic             bclk,
  input  logic             rst_n,
  input  logic             fmt_i2s,
  input  logic             wclk,
  input  logic             sdata,
  output logic [SMP_W-1:0] left_o,
  output logic [SMP_W-1:0] right_o,
  output logic             pair_stb_o,
  output logic             len16_o,
  output logic             err_o
);

  logic             flip;
  logic             latch;
  logic             armed;
  logic             old_lvl;
  logic [CNT_W-1:0] half_len;
  logic [CNT_W-1:0] prev_len;
  logic [SMP_W-1:0] cand;

  srx_edge #(.CNT_W(CNT_W)) u_edge (
    .clk      (bclk),
    .rst_n    (rst_n),
    .wclk     (wclk),
    .flip     (flip),
    .latch    (latch),
    .armed    (armed),
    .old_lvl  (old_lvl),
    .half_len (half_len),
    .prev_len (prev_len)
  );

  srx_shift #(.SMP_W(SMP_W), .I2S_W(I2S_W)) u_shift (
    .clk     (bclk),
    .rst_n   (rst_n),
    .fmt_i2s (fmt_i2s),
    .sdata   (sdata),
    .flip    (flip),
    .cand    (cand)
  );

  srx_frame #(
    .CNT_W   (CNT_W),
    .I2S_W   (I2S_W),
    .RJ_W    (RJ_W),
    .SHORT_W (SHORT_W)
  ) u_frame (
    .clk        (bclk),
    .rst_n      (rst_n),
    .fmt_i2s    (fmt_i2s),
    .latch      (latch),
    .old_lvl    (old_lvl),
    .half_len   (half_len),
    .prev_len   (prev_len),
    .cand       (cand),
    .left_o     (left_o),
    .right_o    (right_o),
    .pair_stb_o (pair_stb_o),
    .len16_o    (len16_o),
    .err_o      (err_o)
  );

  // R10: nothing is reported before the receiver is armed
  a_r10_quiet: assert property (@(posedge bclk) disable iff (!rst_n)
    !armed |-> (!pair_stb_o && !err_o && left_o == '0 && right_o == '0));

endmodule

// File: tb/sim_dual_fmt_audio_rx.sv
`timescale 1ns/1ps
module sim_dual_fmt_audio_rx;

  logic        bclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_i2s = 1'b1;
  logic        wclk = 1'b0;
  logic        sdata = 1'b0;
  logic [23:0] left_o, right_o;
  logic        pair_stb_o, len16_o, err_o;

  int checks = 0;
  int errors = 0;
  int stb_cnt = 0;
  int err_cnt = 0;
  logic [23:0] cap_l = '0, cap_r = '0;
  logic        cap16 = 1'b0;
  logic        spill = 1'b0;
  bit          done = 1'b0;

  always #2 bclk = ~bclk;   // 250 MHz

  dual_fmt_audio_rx u0 (
    .bclk(bclk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .wclk(wclk), .sdata(sdata),
    .left_o(left_o), .right_o(right_o), .pair_stb_o(pair_stb_o),
    .len16_o(len16_o), .err_o(err_o)
  );

  always @(negedge bclk) begin
    if (rst_n) begin
      if (pair_stb_o) begin
        stb_cnt++;
        cap_l = left_o;
        cap_r = right_o;
        cap16 = len16_o;
      end
      if (err_o) err_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edge_out(input logic lvl, input logic b);
    @(negedge bclk);
    wclk  = lvl;
    sdata = b;
  endtask

  task automatic do_reset(input logic fmt);
    @(negedge bclk);
    rst_n = 1'b0; wclk = 1'b0; sdata = 1'b0; fmt_i2s = fmt; spill = 1'b0;
    repeat (3) @(negedge bclk);
    rst_n = 1'b1;
  endtask

  task automatic i2s_half(input logic lvl, input int n, input logic [23:0] val,
                          input int w, input logic pad);
    for (int k = 1; k <= n; k++) begin
      if (k == 1)          edge_out(lvl, spill);
      else if (k - 2 < w)  edge_out(lvl, val[w-1-(k-2)]);
      else                 edge_out(lvl, pad);
    end
    if (n == w)      spill = val[0];
    else if (n > w)  spill = pad;
    else             spill = 1'b0;
  endtask

  task automatic rj_half(input logic lvl, input int n, input logic [23:0] val, input int w);
    for (int k = 1; k <= n; k++) begin
      if (k > n - w) edge_out(lvl, val[n-k]);
      else           edge_out(lvl, 1'b1);   // padding to be discarded
    end
  endtask

  // Arms the receiver and sends one dummy right half before the first frame.
  task automatic preamble(input logic fmt, input int n, input int w);
    do_reset(fmt);
    if (fmt) begin
      edge_out(1'b0, 1'b0); edge_out(1'b0, 1'b0);
      i2s_half(1'b1, n, 24'h0, w, 1'b0);
    end else begin
      edge_out(1'b1, 1'b0); edge_out(1'b1, 1'b0);
      rj_half(1'b0, n, 24'h0, w);
    end
  endtask

  task automatic tail(input logic fmt);
    if (fmt) begin
      edge_out(1'b0, spill); edge_out(1'b0, 1'b0); edge_out(1'b0, 1'b0);
    end else begin
      edge_out(1'b1, 1'b1); edge_out(1'b1, 1'b1); edge_out(1'b1, 1'b1);
    end
    repeat (2) @(negedge bclk);
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    @(negedge bclk);
    chk("R10 left after reset", left_o, 0);
    chk("R10 right after reset", right_o, 0);
    chk("R10 strobe after reset", {pair_stb_o, err_o, len16_o}, 0);
  endtask

  task automatic t_i2s24();
    int s0;
    preamble(1'b1, 24, 24);
    s0 = stb_cnt;
    i2s_half(1'b0, 24, 24'h123456, 24, 1'b0);
    i2s_half(1'b1, 24, 24'hA5C3F0, 24, 1'b0);
    tail(1'b1);
    chk("R7 R10 one strobe i2s24", stb_cnt - s0, 1);
    chk("R1 R2 i2s left", cap_l, 24'h123456);
    chk("R1 R2 i2s right", cap_r, 24'hA5C3F0);
    chk("R5 no len16 i2s24", cap16, 0);
  endtask

  task automatic t_i2s_long();
    int s0;
    preamble(1'b1, 30, 24);
    s0 = stb_cnt;
    i2s_half(1'b0, 30, 24'h800001, 24, 1'b1);
    i2s_half(1'b1, 30, 24'h7FFFFE, 24, 1'b1);
    tail(1'b1);
    chk("R3 strobe long half", stb_cnt - s0, 1);
    chk("R3 extra bits ignored left", cap_l, 24'h800001);
    chk("R3 extra bits ignored right", cap_r, 24'h7FFFFE);
  endtask

  task automatic t_rj20();
    int s0;
    preamble(1'b0, 32, 20);
    s0 = stb_cnt;
    rj_half(1'b1, 32, 24'h07FFFF, 20);
    rj_half(1'b0, 32, 24'h080001, 20);
    tail(1'b0);
    chk("R4 strobe rj20", stb_cnt - s0, 1);
    chk("R4 R6 rj left positive", cap_l, 24'h07FFFF);
    chk("R4 R6 rj right sign filled", cap_r, 24'hF80001);
  endtask

  task automatic t_i2s16();
    int s0;
    preamble(1'b1, 16, 16);
    s0 = stb_cnt;
    i2s_half(1'b0, 16, 24'h008000, 16, 1'b0);
    i2s_half(1'b1, 16, 24'h001234, 16, 1'b0);
    tail(1'b1);
    chk("R5 strobe i2s16", stb_cnt - s0, 1);
    chk("R5 R6 i2s16 left", cap_l, 24'hFF8000);
    chk("R5 i2s16 right", cap_r, 24'h001234);
    chk("R5 len16 flag i2s", cap16, 1);
  endtask

  task automatic t_rj16();
    int s0;
    preamble(1'b0, 16, 16);
    s0 = stb_cnt;
    rj_half(1'b1, 16, 24'h007ABC, 16);
    rj_half(1'b0, 16, 24'h00FFFF, 16);
    tail(1'b0);
    chk("R5 strobe rj16", stb_cnt - s0, 1);
    chk("R5 rj16 left", cap_l, 24'h007ABC);
    chk("R5 R6 rj16 right", cap_r, 24'hFFFFFF);
    chk("R5 len16 flag rj", cap16, 1);
  endtask

  task automatic t_asym();
    int s0;
    preamble(1'b1, 32, 24);
    s0 = stb_cnt;
    i2s_half(1'b0, 24, 24'h0F0F0F, 24, 1'b0);
    i2s_half(1'b1, 48, 24'hF0F0F0, 24, 1'b0);
    i2s_half(1'b0, 24, 24'h000001, 24, 1'b0);
    i2s_half(1'b1, 48, 24'hFFFFFF, 24, 1'b0);
    tail(1'b1);
    chk("R9 R7 two frames two strobes", stb_cnt - s0, 2);
    chk("R9 asym left", cap_l, 24'h000001);
    chk("R9 asym right", cap_r, 24'hFFFFFF);
  endtask

  task automatic t_rj_short();
    int s0, e0;
    preamble(1'b0, 32, 20);
    s0 = stb_cnt;
    e0 = err_cnt;
    rj_half(1'b1, 18, 24'h012345, 18);
    rj_half(1'b0, 18, 24'h023456, 18);
    tail(1'b0);
    chk("R8 short halves no strobe", stb_cnt - s0, 0);
    chk("R8 short halves errors", err_cnt - e0, 2);
    chk("R8 outputs untouched", right_o, 0);
  endtask

  task automatic t_mixed16();
    int s0, e0;
    preamble(1'b1, 32, 24);
    s0 = stb_cnt;
    e0 = err_cnt;
    i2s_half(1'b0, 16, 24'h001111, 16, 1'b0);
    i2s_half(1'b1, 24, 24'h222222, 24, 1'b0);
    tail(1'b1);
    chk("R5 R8 one 16 half no strobe", stb_cnt - s0, 0);
    chk("R5 R8 one 16 half error", err_cnt - e0, 1);
  endtask

  initial begin
    t_reset();
    t_i2s24();
    t_i2s_long();
    t_rj20();
    t_i2s16();
    t_rj16();
    t_asym();
    t_rj_short();
    t_mixed16();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge bclk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule